// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block keeps a small fully associative record of loads that a scheduler has moved above earlier stores. When such a load issues, its memory address and its destination register number are written into a slot. Every later store searches all occupied slots by address and marks each match as conflicted. This means the early value may be stale.

Before the early value is consumed for real, a check names the register and the recovery style. The table looks the register up and answers one cycle later. A clean slot means pass. A marked slot, or no slot at all, means failure. On a failure of the reload style, the block asks for the load to be re-issued. On a failure of the branch style, it hands back the address of a fix-up routine that came with the check. That routine redoes the load and every instruction that used the early value. A check always releases the slot it finds. The block only reports recovery and does not carry it out.

Top module: `hoist_ld_table`

## Requirements
- R1: After reset no slot is occupied and `rsp_vld` is low. `rsp_vld` is high in exactly the cycle after each cycle with `chk_vld` high.
- R2: An allocation records its address and its 7-bit register number (0 to 127). A later check of that register, with no matching store in between, answers with `rsp_pass`.
- R3: A store whose address equals the address of an occupied slot marks that slot. A store to any other address leaves the slot unmarked.
- R4: A failed check with `chk_kind` = 0 (reload style) raises `rsp_reload`, and `rsp_target` is 0.
- R5: A failed check with `chk_kind` = 1 (branch style) raises `rsp_branch`, and `rsp_target` equals the `chk_target` given with the check.
- R6: A check that finds the register's slot frees that slot, whether it passes or fails. A second check of the same register therefore fails.
- R7: A check of a register that has no slot fails.
- R8: An allocation and a store to the same address in the same cycle leave the new slot marked.
- R9: An allocation to a register that already holds a slot overwrites that slot's address and clears its mark.
- R10: An allocation takes the lowest-numbered free slot. When all slots are occupied, it evicts slots in round-robin order starting at slot 0, and a later check of the evicted register fails.
- R11: A check is judged on the table as it stood before that cycle's allocation and store. A same-cycle store does not spoil it. A same-cycle allocation of the checked register survives the check.
- R12: While `rsp_vld` is high, exactly one of `rsp_pass`, `rsp_reload` and `rsp_branch` is high. While it is low, all three are low and `rsp_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_vld | input | 1 | Hoisted load issues this cycle |
| alloc_addr | input | AW | Address the hoisted load read |
| alloc_reg | input | RW | Destination register of the hoisted load |
| st_vld | input | 1 | Store issues this cycle |
| st_addr | input | AW | Store address |
| chk_vld | input | 1 | Check issues this cycle |
| chk_reg | input | RW | Register being checked |
| chk_kind | input | 1 | 0 = reload style, 1 = branch style |
| chk_target | input | AW | Fix-up routine address for branch style |
| rsp_vld | output | 1 | Check answer valid |
| rsp_pass | output | 1 | Early value is safe |
| rsp_reload | output | 1 | Re-issue the load |
| rsp_branch | output | 1 | Jump to fix-up routine |
| rsp_target | output | AW | Fix-up routine address, else 0 |

## Verification
The assertions assume that `chk_kind` and `chk_target` are driven to known values whenever `chk_vld` is high, since the answer copies them one cycle later. They also assume that reset is applied before the first check. The stimulus drives every input at the falling edge and keeps it stable through the next rising edge. It returns the check fields to zero when no check is issued, so a branch answer can only carry the address given with its own check.

// File: rtl/hoist_ld_pkg.sv
package hoist_ld_pkg;

    typedef enum logic {
        KIND_RELOAD = 1'b0,
        KIND_BRANCH = 1'b1
    } chk_kind_e;

endpackage

// File: rtl/hoist_ld_tag_cam.sv
// Searches all occupied slots for a register tag; tags are unique among
// occupied slots, so at most one bit of the match vector is set.
module hoist_ld_tag_cam #(
    parameter int DEPTH = 16,
    parameter int RW    = 7,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]         vld,
    input  logic [DEPTH-1:0][RW-1:0] tags,
    input  logic [RW-1:0]            key,
    output logic                     hit,
    output logic [IW-1:0]            idx
);

    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) idx = IW'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/hoist_ld_free_pick.sv
// Lowest-numbered unoccupied slot.
module hoist_ld_free_pick #(
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vld,
    output logic             any,
    output logic [IW-1:0]    idx
);

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IW'(i);
        end
    end

    assign any = ~&vld;

endmodule

// File: rtl/hoist_ld_table.sv
module hoist_ld_table
    import hoist_ld_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int RW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_vld,
    input  logic [AW-1:0] alloc_addr,
    input  logic [RW-1:0] alloc_reg,
    input  logic          st_vld,
    input  logic [AW-1:0] st_addr,
    input  logic          chk_vld,
    input  logic [RW-1:0] chk_reg,
    input  logic          chk_kind,
    input  logic [AW-1:0] chk_target,
    output logic          rsp_vld,
    output logic          rsp_pass,
    output logic          rsp_reload,
    output logic          rsp_branch,
    output logic [AW-1:0] rsp_target
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IW-1:0] LAST_SLOT = IW'(DEPTH - 1);

    typedef struct packed {
        logic          vld;
        logic          flag;
        logic [RW-1:0] tag;
        logic [AW-1:0] addr;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [IW-1:0]     rr;
        logic              rsp_vld;
        logic              rsp_pass;
        logic              rsp_reload;
        logic              rsp_branch;
        logic [AW-1:0]     rsp_target;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0]         vld_q;
    logic [DEPTH-1:0][RW-1:0] tag_q;
    logic [DEPTH-1:0]         vld_post_chk;
    logic                     chk_hit, al_hit, free_any;
    logic [IW-1:0]            chk_idx, al_idx, free_idx;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_q[i] = s_q.slot[i].vld;
            tag_q[i] = s_q.slot[i].tag;
        end
    end

    hoist_ld_tag_cam #(.DEPTH(DEPTH), .RW(RW)) u_chk_cam (
        .vld  (vld_q),
        .tags (tag_q),
        .key  (chk_reg),
        .hit  (chk_hit),
        .idx  (chk_idx)
    );

    hoist_ld_tag_cam #(.DEPTH(DEPTH), .RW(RW)) u_alloc_cam (
        .vld  (vld_q),
        .tags (tag_q),
        .key  (alloc_reg),
        .hit  (al_hit),
        .idx  (al_idx)
    );

    // Occupancy once this cycle's check has released its slot.
    always_comb begin
        vld_post_chk = vld_q;
        if (chk_vld && chk_hit) vld_post_chk[chk_idx] = 1'b0;
    end

    hoist_ld_free_pick #(.DEPTH(DEPTH)) u_free (
        .vld (vld_post_chk),
        .any (free_any),
        .idx (free_idx)
    );

    always_comb begin
        logic [IW-1:0] wr_idx;
        s_d            = s_q;
        s_d.rsp_vld    = 1'b0;
        s_d.rsp_pass   = 1'b0;
        s_d.rsp_reload = 1'b0;
        s_d.rsp_branch = 1'b0;
        s_d.rsp_target = '0;
        wr_idx         = '0;

        // 1. check, judged on the registered table
        if (chk_vld) begin
            s_d.rsp_vld = 1'b1;
            if (chk_hit) s_d.slot[chk_idx].vld = 1'b0;
            if (chk_hit && !s_q.slot[chk_idx].flag) begin
                s_d.rsp_pass = 1'b1;
            end else if (chk_kind_e'(chk_kind) == KIND_BRANCH) begin
                s_d.rsp_branch = 1'b1;
                s_d.rsp_target = chk_target;
            end else begin
                s_d.rsp_reload = 1'b1;
            end
        end

        // 2. allocation: same register, else free slot, else round-robin victim
        if (alloc_vld) begin
            if (al_hit) begin
                wr_idx = al_idx;
            end else if (free_any) begin
                wr_idx = free_idx;
            end else begin
                wr_idx = s_q.rr;
                s_d.rr = (s_q.rr == LAST_SLOT) ? '0 : s_q.rr + 1'b1;
            end
            s_d.slot[wr_idx].vld  = 1'b1;
            s_d.slot[wr_idx].flag = 1'b0;
            s_d.slot[wr_idx].tag  = alloc_reg;
            s_d.slot[wr_idx].addr = alloc_addr;
        end

        // 3. store search, sees this cycle's allocation
        if (st_vld) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (s_d.slot[i].vld && (s_d.slot[i].addr == st_addr)) begin
                    s_d.slot[i].flag = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_vld    = s_q.rsp_vld;
    assign rsp_pass   = s_q.rsp_pass;
    assign rsp_reload = s_q.rsp_reload;
    assign rsp_branch = s_q.rsp_branch;
    assign rsp_target = s_q.rsp_target;

endmodule

// File: rtl/hoist_ld_table_chk.sv
module hoist_ld_table_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chk_vld,
    input logic          chk_kind,
    input logic [AW-1:0] chk_target,
    input logic          rsp_vld,
    input logic          rsp_pass,
    input logic          rsp_reload,
    input logic          rsp_branch,
    input logic [AW-1:0] rsp_target
);

    a_r1_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |=> rsp_vld);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld |=> !rsp_vld);

    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $countones({rsp_pass, rsp_reload, rsp_branch}) == 1);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> !(rsp_pass || rsp_reload || rsp_branch) && rsp_target == '0);

    a_r4_reload_kind: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reload |-> $past(chk_kind) == 1'b0 && rsp_target == '0);

    a_r5_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_branch |-> $past(chk_kind) == 1'b1 && rsp_target == $past(chk_target));

    a_r5_target_only_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_branch |-> rsp_target == '0);

endmodule

bind hoist_ld_table hoist_ld_table_chk #(.AW(AW)) u_hoist_ld_table_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_vld    (chk_vld),
    .chk_kind   (chk_kind),
    .chk_target (chk_target),
    .rsp_vld    (rsp_vld),
    .rsp_pass   (rsp_pass),
    .rsp_reload (rsp_reload),
    .rsp_branch (rsp_branch),
    .rsp_target (rsp_target)
);

// File: tb/test_hoist_ld_table.sv
`timescale 1ns/1ps
module test_hoist_ld_table;

    localparam int DEPTH = 16;
    localparam int AW    = 32;
    localparam int RW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_vld = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic [RW-1:0] alloc_reg = '0;
    logic          st_vld = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic          chk_vld = 1'b0;
    logic [RW-1:0] chk_reg = '0;
    logic          chk_kind = 1'b0;
    logic [AW-1:0] chk_target = '0;
    logic          rsp_vld, rsp_pass, rsp_reload, rsp_branch;
    logic [AW-1:0] rsp_target;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    hoist_ld_table #(.DEPTH(DEPTH), .AW(AW), .RW(RW)) i_hoist_ld_table (
        .clk, .rst_n, .alloc_vld, .alloc_addr, .alloc_reg, .st_vld, .st_addr,
        .chk_vld, .chk_reg, .chk_kind, .chk_target,
        .rsp_vld, .rsp_pass, .rsp_reload, .rsp_branch, .rsp_target
    );

    // ---------------- behavioural reference model ----------------
    bit          m_vld  [DEPTH];
    bit          m_flag [DEPTH];
    int          m_tag  [DEPTH];
    logic [AW-1:0] m_addr [DEPTH];
    int          m_rr;
    bit          e_vld, e_pass, e_rel, e_br;
    logic [AW-1:0] e_tgt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_vld[i] = 0; m_flag[i] = 0; m_tag[i] = 0; m_addr[i] = '0;
            end
            m_rr = 0;
            e_vld = 0; e_pass = 0; e_rel = 0; e_br = 0; e_tgt = '0;
        end else begin
            int ch, ah, w;
            bit vnow [DEPTH];
            ch = -1; ah = -1; w = -1;
            for (int i = 0; i < DEPTH; i++) begin
                if (m_vld[i] && m_tag[i] == int'(chk_reg))   ch = i;
                if (m_vld[i] && m_tag[i] == int'(alloc_reg)) ah = i;
                vnow[i] = m_vld[i];
            end
            e_vld = chk_vld; e_pass = 0; e_rel = 0; e_br = 0; e_tgt = '0;
            if (chk_vld) begin
                if (ch >= 0 && !m_flag[ch]) e_pass = 1;
                else if (chk_kind) begin e_br = 1; e_tgt = chk_target; end
                else e_rel = 1;
                if (ch >= 0) m_vld[ch] = 0;
            end
            if (alloc_vld) begin
                if (ah >= 0) w = ah;
                else begin
                    for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) w = i;
                    if (w < 0) begin w = m_rr; m_rr = (m_rr + 1) % DEPTH; end
                end
                m_vld[w] = 1; m_flag[w] = 0; m_tag[w] = int'(alloc_reg); m_addr[w] = alloc_addr;
            end
            if (st_vld)
                for (int i = 0; i < DEPTH; i++)
                    if (m_vld[i] && m_addr[i] == st_addr) m_flag[i] = 1;
            if (vnow[0] === 1'bx) e_vld = 0;
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if ({rsp_vld, rsp_pass, rsp_reload, rsp_branch} !== {e_vld, e_pass, e_rel, e_br}
                || rsp_target !== e_tgt) begin
                n_fail++;
                $display("FAIL %s model: actual v=%b p=%b r=%b b=%b t=%h expected v=%b p=%b r=%b b=%b t=%h",
                         cur_req, rsp_vld, rsp_pass, rsp_reload, rsp_branch, rsp_target,
                         e_vld, e_pass, e_rel, e_br, e_tgt);
            end
        end
    end

    // ---------------- stimulus tasks (drive at falling edge) ----------------
    task automatic idle();
        alloc_vld = 0; st_vld = 0; chk_vld = 0;
        chk_kind = 0; chk_target = '0; chk_reg = '0;
    endtask

    task automatic cycle_end();
        @(negedge clk);
        idle();
    endtask

    task automatic do_alloc(input int r, input logic [AW-1:0] a);
        alloc_vld = 1; alloc_reg = RW'(r); alloc_addr = a;
        cycle_end();
    endtask

    task automatic do_store(input logic [AW-1:0] a);
        st_vld = 1; st_addr = a;
        cycle_end();
    endtask

    // check, then compare the answer against requirement-derived values
    task automatic do_check(input int r, input bit kind, input logic [AW-1:0] tgt,
                            input bit exp_pass, input string req);
        logic [AW-1:0] et;
        chk_vld = 1; chk_reg = RW'(r); chk_kind = kind; chk_target = tgt;
        cycle_end();
        et = (!exp_pass && kind) ? tgt : '0;
        n_tests++;
        if (rsp_vld !== 1'b1 || rsp_pass !== exp_pass
            || rsp_reload !== (!exp_pass && !kind) || rsp_branch !== (!exp_pass && kind)
            || rsp_target !== et) begin
            n_fail++;
            $display("FAIL %s check r%0d: actual v=%b p=%b r=%b b=%b t=%h expected pass=%b kind=%b t=%h",
                     req, r, rsp_vld, rsp_pass, rsp_reload, rsp_branch, rsp_target,
                     exp_pass, kind, et);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        idle();
        repeat (3) @(negedge clk);
        // R1: reset state
        n_tests++;
        if (rsp_vld !== 1'b0 || rsp_target !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: actual v=%b t=%h expected v=0 t=0", rsp_vld, rsp_target);
        end
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1"; do_check(5, 0, '0, 0, "R1");

        cur_req = "R2"; do_alloc(10, 32'h0000_1000); do_check(10, 0, '0, 1, "R2");
        do_alloc(127, 32'h0000_1FC0); do_check(127, 1, 32'hABCD_0000, 1, "R2");

        cur_req = "R3"; do_alloc(11, 32'h0000_2000); do_store(32'h0000_2004);
        do_check(11, 0, '0, 1, "R3");
        do_alloc(11, 32'h0000_2000); do_store(32'h0000_2000);
        cur_req = "R4"; do_check(11, 0, 32'h5555_0000, 0, "R4");

        cur_req = "R5"; do_alloc(12, 32'h0000_3000); do_store(32'h0000_3000);
        do_check(12, 1, 32'hCAFE_0100, 0, "R5");

        cur_req = "R6"; do_alloc(13, 32'h0000_4000); do_check(13, 0, '0, 1, "R6");
        do_check(13, 0, '0, 0, "R6");

        cur_req = "R7"; do_check(99, 1, 32'h0000_0777, 0, "R7");

        cur_req = "R8";
        alloc_vld = 1; alloc_reg = 7'd14; alloc_addr = 32'h0000_5000;
        st_vld = 1; st_addr = 32'h0000_5000;
        cycle_end();
        do_check(14, 0, '0, 0, "R8");

        cur_req = "R9"; do_alloc(15, 32'h0000_6000); do_store(32'h0000_6000);
        do_alloc(15, 32'h0000_6100); do_store(32'h0000_6000);
        do_check(15, 0, '0, 1, "R9");

        // R10: table is empty here; fill slots 0..15 with r20..r35
        cur_req = "R10";
        for (int k = 0; k < DEPTH; k++) do_alloc(20 + k, 32'h0001_0000 + 32'(k * 64));
        do_alloc(36, 32'h0002_0000);             // evicts slot 0 (r20)
        do_check(20, 0, '0, 0, "R10");
        do_check(21, 0, '0, 1, "R10");
        do_check(36, 1, 32'h0000_0ABC, 1, "R10");
        do_alloc(37, 32'h0002_0040);             // free slot exists, no eviction
        do_check(22, 0, '0, 1, "R10");
        do_check(37, 0, '0, 1, "R10");

        cur_req = "R11"; do_alloc(40, 32'h0003_0000);
        chk_vld = 1; chk_reg = 7'd40; chk_kind = 0;
        st_vld = 1; st_addr = 32'h0003_0000;
        cycle_end();
        n_tests++;
        if (rsp_pass !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 same-cycle store: actual pass=%b expected 1", rsp_pass);
        end
        do_check(40, 0, '0, 0, "R11");
        do_alloc(41, 32'h0003_1000);
        chk_vld = 1; chk_reg = 7'd41; chk_kind = 0;
        alloc_vld = 1; alloc_reg = 7'd41; alloc_addr = 32'h0003_2000;
        cycle_end();
        n_tests++;
        if (rsp_pass !== 1'b1) begin
            n_fail++;
            $display("FAIL R11 same-cycle alloc: actual pass=%b expected 1", rsp_pass);
        end
        do_check(41, 0, '0, 1, "R11");

        cur_req = "R12";
        repeat (2) @(negedge clk);
        n_tests++;
        if ({rsp_vld, rsp_pass, rsp_reload, rsp_branch} !== 4'b0 || rsp_target !== '0) begin
            n_fail++;
            $display("FAIL R12 idle: actual v=%b p=%b r=%b b=%b t=%h expected all 0",
                     rsp_vld, rsp_pass, rsp_reload, rsp_branch, rsp_target);
        end

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule